// File: doc/BRIEF.md
# Buffered-Write Stall Controller

This block decides, for every CPU store that bypasses the cache or goes through it in write-through fashion, whether the processor may move on at once or must wait for the bus to confirm that the write has completed. Copy-back cached stores never wait here. The choice comes from one of three places: a per-area bit in a 32-bit control register, the buffered-write bit of the matching translation entry, or the buffered-write bit of the matching fixed-mapping entry. The source depends on the addressing mode, on whether the MMU is on, and on which region the store falls in.

The control register holds a mode bit and eight per-area bits, and is accessed through a plain write strobe with a combinational read value. When a store is accepted and needs to wait, the block raises `stall` and keeps it high until the bus returns a one-cycle write-done pulse. No new store is accepted while `stall` is high.

Top module: `bwr_stall_ctrl`

## Requirements
- R1: After reset the control register reads 0x00000000, `stall` is low and `st_accept` follows `st_valid`.
- R2: A register write stores bit 31 (mode: 0 = 29-bit addressing, 1 = 32-bit extended) and bits 7:0 (per-area wait bits). Bits 30:8 always read 0 and ignore writes.
- R3: A store with `st_cached`=1 and `st_wthru`=0 (copy-back) never causes a stall, whatever the mode, region or entry bits.
- R4: In 29-bit mode, an uncached or write-through store stalls exactly when per-area bit `ub[st_addr[28:26]]` is 1.
- R5: In 32-bit mode, a store to 0xE0000000 to 0xFFFFFFFF stalls exactly when `ub[7]` is 1. Bits 6:0 have no effect in this mode.
- R6: In 32-bit mode, a store to 0x80000000 to 0xBFFFFFFF stalls exactly when `fixmap_ub` is 1.
- R7: In 32-bit mode with `mmu_on`=1, a store below 0x80000000 or in 0xC0000000 to 0xDFFFFFFF stalls exactly when `tlb_ub` is 1.
- R8: In 32-bit mode with `mmu_on`=0, a store below 0x80000000 or in 0xC0000000 to 0xDFFFFFFF never stalls.
- R9: A store is accepted in a cycle where `st_valid`=1 and `stall`=0. If it must wait, `stall` is high from the next cycle. It stays high until the cycle after `wr_done` is sampled high, and `st_accept` stays low during that time.
- R10: A `wr_done` pulse while `stall` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write value |
| reg_rdata | output | 32 | Control register read value |
| st_valid | input | 1 | Store request present |
| st_addr | input | 32 | Store address |
| st_cached | input | 1 | Store goes to a cacheable page |
| st_wthru | input | 1 | Cacheable page uses write-through |
| mmu_on | input | 1 | Address translation enabled |
| tlb_ub | input | 1 | Buffered-write bit of the matching translation entry |
| fixmap_ub | input | 1 | Buffered-write bit of the matching fixed-mapping entry |
| wr_done | input | 1 | One-cycle pulse: bus finished the pending write |
| st_accept | output | 1 | Store taken this cycle |
| stall | output | 1 | CPU must wait for write completion |

## Verification
The hardest case to reach is the 32-bit mode region split, because one store outcome depends on five inputs at the same time: the mode bit, the low per-area bits, `mmu_on`, and both entry bits. The bench therefore sets the low per-area bits to 1 while `ub[7]` is 0, and sets the entry bits to disagree with the expected outcome, so that a wrong source selection shows up as a wrong `stall`. The hold window is tested by offering a second store while stalled, and by sending a stray `wr_done` pulse while idle.

// File: rtl/bwr_pkg.sv
`timescale 1ns/1ps
package bwr_pkg;

  // Region classes that pick the buffered-write source in extended mode
  typedef enum logic [1:0] {
    RGN_XLAT = 2'd0,  // P0/U0 and P3: translation entry
    RGN_FIX  = 2'd1,  // P1/P2: fixed-mapping entry
    RGN_CTL  = 2'd2   // control area: register top bit
  } rgn_e;

  function automatic rgn_e region_of(input logic [2:0] top3);
    case (top3)
      3'b111:         return RGN_CTL;
      3'b100, 3'b101: return RGN_FIX;
      default:        return RGN_XLAT;
    endcase
  endfunction

  // Only uncached or write-through stores are subject to the decision
  function automatic logic is_bypass(input logic cached, input logic wthru);
    return !cached || wthru;
  endfunction

endpackage

// File: rtl/bwr_ctl_reg.sv
`timescale 1ns/1ps
module bwr_ctl_reg #(
  parameter int DATA_W   = 32,
  parameter int N_AREA   = 8,
  parameter int MODE_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              mode_ext,
  output logic [N_AREA-1:0] area_ub
);

  logic              mode_q;
  logic [N_AREA-1:0] ub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ub_q   <= '0;
    end else if (wr_en) begin
      mode_q <= wdata[MODE_BIT];
      ub_q   <= wdata[N_AREA-1:0];
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_rd
    if (i == MODE_BIT) begin : g_mode
      assign rdata[i] = mode_q;
    end else if (i < N_AREA) begin : g_area
      assign rdata[i] = ub_q[i];
    end else begin : g_rsvd
      assign rdata[i] = 1'b0;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  assign mode_ext = mode_q;
  assign area_ub  = ub_q;

endmodule

// File: rtl/bwr_src_sel.sv
`timescale 1ns/1ps
module bwr_src_sel
  import bwr_pkg::*;
#(
  parameter int N_AREA   = 8,
  parameter int AREA_LSB = 26,
  localparam int AREA_W  = $clog2(N_AREA)
) (
  input  logic              mode_ext,
  input  logic [N_AREA-1:0] area_ub,
  input  logic [2:0]        top3,
  input  logic [AREA_W-1:0] area_idx,
  input  logic              cached,
  input  logic              wthru,
  input  logic              mmu_on,
  input  logic              tlb_ub,
  input  logic              fixmap_ub,
  output logic              bypass,
  output logic              need_wait
);

  rgn_e rgn;
  logic ext_wait;

  assign rgn    = region_of(top3);
  assign bypass = is_bypass(cached, wthru);

  always_comb begin
    case (rgn)
      RGN_CTL:  ext_wait = area_ub[N_AREA-1];
      RGN_FIX:  ext_wait = fixmap_ub;
      default:  ext_wait = mmu_on & tlb_ub;
    endcase
  end

  assign need_wait = bypass & (mode_ext ? ext_wait : area_ub[area_idx]);

endmodule

// File: rtl/bwr_stall_hold.sv
`timescale 1ns/1ps
module bwr_stall_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic st_valid,
  input  logic need_wait,
  input  logic wr_done,
  output logic accept,
  output logic stall
);

  logic stall_q;

  assign accept = st_valid & ~stall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stall_q <= 1'b0;
    else if (stall_q)
      stall_q <= ~wr_done;
    else
      stall_q <= accept & need_wait;
  end

  assign stall = stall_q;

endmodule

// File: rtl/bwr_stall_ctrl.sv
`timescale 1ns/1ps
module bwr_stall_ctrl #(
  parameter int DATA_W   = 32,
  parameter int N_AREA   = 8,
  parameter int MODE_BIT = 31,
  parameter int AREA_LSB = 26,
  localparam int AREA_W  = $clog2(N_AREA)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        st_valid,
  input  logic [31:0] st_addr,
  input  logic        st_cached,
  input  logic        st_wthru,
  input  logic        mmu_on,
  input  logic        tlb_ub,
  input  logic        fixmap_ub,
  input  logic        wr_done,
  output logic        st_accept,
  output logic        stall
);

  logic              mode_ext;
  logic [N_AREA-1:0] area_ub;
  logic              bypass;
  logic              need_wait;

  bwr_ctl_reg #(.DATA_W(DATA_W), .N_AREA(N_AREA), .MODE_BIT(MODE_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .rdata(reg_rdata), .mode_ext(mode_ext), .area_ub(area_ub)
  );

  bwr_src_sel #(.N_AREA(N_AREA), .AREA_LSB(AREA_LSB)) u_sel (
    .mode_ext(mode_ext), .area_ub(area_ub),
    .top3(st_addr[31:29]), .area_idx(st_addr[AREA_LSB +: AREA_W]),
    .cached(st_cached), .wthru(st_wthru), .mmu_on(mmu_on),
    .tlb_ub(tlb_ub), .fixmap_ub(fixmap_ub),
    .bypass(bypass), .need_wait(need_wait)
  );

  bwr_stall_hold u_hold (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .need_wait(need_wait),
    .wr_done(wr_done), .accept(st_accept), .stall(stall)
  );

  logic unused_addr;
  assign unused_addr = ^{st_addr[AREA_LSB-1:0]};

endmodule

// File: rtl/bwr_stall_chk.sv
`timescale 1ns/1ps
module bwr_stall_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rdata,
  input logic        st_accept,
  input logic        stall,
  input logic        wr_done,
  input logic        bypass,
  input logic        need_wait
);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[30:8] == '0);

  // R3
  copyback_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_accept && !bypass) |=> !stall);

  // R9
  no_accept_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !st_accept);

  // R9
  stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_accept && need_wait) |=> stall);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !wr_done) |=> stall);

  // R9
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && wr_done) |=> !stall);

  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !(st_accept && need_wait)) |=> !stall);

endmodule

bind bwr_stall_ctrl bwr_stall_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .st_accept(st_accept),
  .stall(stall), .wr_done(wr_done), .bypass(bypass), .need_wait(need_wait)
);

// File: tb/test_bwr_stall_ctrl.sv
`timescale 1ns/1ps
module test_bwr_stall_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic        st_cached = 1'b0, st_wthru = 1'b0, mmu_on = 1'b0;
  logic        tlb_ub = 1'b0, fixmap_ub = 1'b0, wr_done = 1'b0;
  logic        st_accept, stall;

  int vectors = 0;
  int miscompares = 0;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];

  logic [31:0] model_reg = '0;

  always #2 clk = ~clk;

  bwr_stall_ctrl i_bwr_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .st_valid(st_valid), .st_addr(st_addr),
    .st_cached(st_cached), .st_wthru(st_wthru), .mmu_on(mmu_on),
    .tlb_ub(tlb_ub), .fixmap_ub(fixmap_ub), .wr_done(wr_done),
    .st_accept(st_accept), .stall(stall)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic expect_wait(input logic [31:0] cr, input logic [31:0] a,
      input logic c, input logic wt, input logic mmu, input logic tlb, input logic fix);
    if (c && !wt) return 1'b0;
    if (!cr[31]) return cr[(a >> 26) & 32'd7];
    if (a >= 32'hE000_0000) return cr[7];
    if (a >= 32'h8000_0000 && a < 32'hC000_0000) return fix;
    return mmu ? tlb : 1'b0;
  endfunction

  task automatic write_reg(input logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
    model_reg = v & 32'h8000_00FF;
    check("R2", reg_rdata, model_reg);
  endtask

  // Driver: issues one store, pushes the expected stall into the scoreboard
  task automatic do_store(input string tag, input logic [31:0] a, input logic c,
      input logic wt, input logic mmu, input logic tlb, input logic fix);
    item_t it;
    @(negedge clk);
    st_addr = a; st_cached = c; st_wthru = wt; mmu_on = mmu;
    tlb_ub = tlb; fixmap_ub = fix; st_valid = 1'b1;
    #1 check("R9 accept", {31'd0, st_accept}, 32'd1);
    it.exp = expect_wait(model_reg, a, c, wt, mmu, tlb, fix);
    it.tag = tag;
    @(posedge clk);
    sb_q.push_back(it);
    @(negedge clk);
    st_valid = 1'b0;
    if (it.exp) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R9 hold", {31'd0, stall}, 32'd1);
        st_valid = 1'b1;
        #1 check("R9 no accept", {31'd0, st_accept}, 32'd0);
        st_valid = 1'b0;
      end
      wr_done = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
      check("R9 release", {31'd0, stall}, 32'd0);
    end
  endtask

  // Monitor: compares stall one cycle after each accepted store
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, {31'd0, stall}, {31'd0, it.exp});
      end
    end
  end

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reg", reg_rdata, 32'h0);
    check("R1 stall", {31'd0, stall}, 32'd0);
    st_valid = 1'b1;
    #1 check("R1 accept", {31'd0, st_accept}, 32'd1);
    st_valid = 1'b0;

    // R2
    write_reg(32'hFFFF_FFFF);
    write_reg(32'h0000_00A5);

    // R4: each area in 29-bit mode, top bits varied
    for (int ar = 0; ar < 8; ar++)
      do_store("R4 area", (32'(ar) << 26) | (32'(ar & 7) << 29) | 32'h40,
               1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    do_store("R4 wthru", 32'h0000_0100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R3
    do_store("R3 copyback", 32'h0000_0100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    // R10: stray done while idle, then a non-waiting store
    @(negedge clk); wr_done = 1'b1;
    @(negedge clk); wr_done = 1'b0;
    check("R10 idle", {31'd0, stall}, 32'd0);
    do_store("R10 after", 32'h0400_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // 32-bit mode, ub[7]=0 with low bits set
    write_reg(32'h8000_007F);
    do_store("R5 ctl off", 32'hE000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    do_store("R8 p0 mmu off", 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    do_store("R8 p3 mmu off", 32'hC400_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    write_reg(32'h8000_0080);
    do_store("R5 ctl on", 32'hFFFF_FFF0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_store("R6 p1 fix1", 32'h8000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    do_store("R6 p1 fix0", 32'h9C00_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    do_store("R6 p2 fix1", 32'hA000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    do_store("R7 p0 tlb1", 32'h7FFF_FFFC, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    do_store("R7 p0 tlb0", 32'h0400_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    do_store("R7 p3 tlb1", 32'hDFFF_FFFC, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    do_store("R3 copyback ext", 32'hA000_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);

    repeat (3) @(negedge clk);
    check("R9 queue drained", 32'(sb_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule